// File: doc/BRIEF.md
# Segmented and Paged Address Translator

This block converts a 32-bit virtual address into a physical address within the same cycle. It has three paths. When translation is switched off, the address passes through unchanged. When the address falls in a segment marked for direct mapping, a 4-bit physical segment base replaces the top nibble. In every other case a page lookup runs in a 4-way, 16-index translation buffer. That lookup uses 8 KB pages, matches on the process ID, and checks protection.

Software fills the translation buffer through a one-entry-per-cycle write port, addressed by way and index. After a paged access that misses or faults, two registers record the event on the next clock edge. The fault-record register holds the page number, the access direction and the process ID. The refill-slot register holds the way and index where a handler should place the missing entry. The refill handler itself and the exception vectoring lie outside this block.

Top module: `mmu_xlate`

## Requirements
- R1: When `xl_mode` is 2'b00, `pa` equals `va`, `xl_miss` is 0 and `xl_fault` is 0, whatever the other inputs are.
- R2: When `xl_mode` is non-zero and `seg_direct[va[31:28]]` is 1, the access is direct. Then `pa` is `{base, va[27:0]}`, with `xl_miss`=0 and `xl_fault`=0. For segments 0..7, `base` is `kbase_lo[4s+3:4s]`; for segments 8..15 it is `kbase_hi[4(s-8)+3:4(s-8)]`.
- R3: When an access is paged and an entry hits, `pa` is `{lo[31:13], va[12:0]}` of that entry. This holds whether or not a protection fault is reported.
- R4: A write with `tlb_we`=1 stores `tlb_hi`/`tlb_lo` at way `tlb_set`, index `tlb_idx`. A lookup reads all four ways at index `va[16:13]`. A way matches only when its `hi[31:13]` equals `va[31:13]`.
- R5: A way whose global bit `lo[4]` is 0 matches only when `hi[7:0]` equals `cur_pid`.
- R6: When several ways match, the lowest-numbered way supplies the result.
- R7: A paged access that matches no way gives `xl_miss`=1 and `xl_fault`=1 (refill). In that case `pa` equals `va`.
- R8: With `chk_valid`=1, a hit on an entry whose valid bit `lo[3]` is 0 gives `xl_fault`=2 (invalid) and `xl_miss`=1.
- R9: With `chk_kern`=1, a user access (`acc_user`=1) that hits an entry whose kernel bit `lo[2]` is 1 gives `xl_fault`=3 (privilege) and `xl_miss`=1.
- R10: With `chk_wr`=1, a write that hits an entry whose writable bit `lo[1]` is 0 gives `xl_fault`=4 (write-protect) and `xl_miss`=1. A hit with no fault gives `xl_fault`=0 and `xl_miss`=0.
- R11: When more than one fault condition holds, the reported kind follows the order invalid, then privilege, then write-protect.
- R12: One edge after an access with `acc_valid`=1 that reports a refill, `mm_sel` becomes `{2'b00, va[16:13]}` (way in bits 5:4, index in bits 3:0). Every other access leaves it unchanged.
- R13: One edge after a paged access with `acc_valid`=1 and `xl_miss`=1, `mm_cause` becomes the following, with all other bits 0:
  - bits 31:13 hold `va[31:13]`;
  - bits 9:8 hold 2'b01 for a read or 2'b10 for a write;
  - bits 7:0 hold `cur_pid`.

  Otherwise `mm_cause` holds its value. `rst` clears both `mm_cause` and `mm_sel` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_mode | input | 2 | Translation on when non-zero |
| seg_direct | input | 16 | Per-segment direct-mapping select |
| kbase_lo | input | 32 | Physical bases for segments 0..7, 4 bits each |
| kbase_hi | input | 32 | Physical bases for segments 8..15, 4 bits each |
| chk_wr | input | 1 | Enable write-protect check |
| chk_kern | input | 1 | Enable privilege check |
| chk_valid | input | 1 | Enable valid-bit check |
| acc_valid | input | 1 | Access is real; allows register capture |
| va | input | 32 | Virtual address |
| acc_wr | input | 1 | 1 for write access |
| acc_user | input | 1 | 1 for user-mode access |
| cur_pid | input | 8 | Current process ID |
| tlb_we | input | 1 | Buffer write strobe |
| tlb_set | input | 2 | Way to write |
| tlb_idx | input | 4 | Index to write |
| tlb_hi | input | 32 | Tag word: page number 31:13, PID 7:0 |
| tlb_lo | input | 32 | Data word: frame 31:13, flags 4:0 |
| pa | output | 32 | Physical address |
| xl_miss | output | 1 | Miss or fault on a paged access |
| xl_fault | output | 3 | 0 none, 1 refill, 2 invalid, 3 privilege, 4 write-protect |
| mm_cause | output | 32 | Fault-record register |
| mm_sel | output | 6 | Refill-slot register |

## Verification
`pa`, `xl_miss` and `xl_fault` are combinational. The bench samples them 1 ns after it drives an access, before the next rising edge. `mm_cause` and `mm_sel` change on the first rising edge after an access that captures, so the bench samples them 1 ns after that edge. It also checks them again after accesses that must leave them untouched. The sweep covers every stored entry under all eight check-enable combinations, with matching and mismatching PIDs and with both access directions and both privilege modes.

// File: rtl/mmu_xlate_pkg.sv
`timescale 1ns/1ps
package mmu_xlate_pkg;

  typedef enum logic [2:0] {
    FK_NONE    = 3'd0,
    FK_REFILL  = 3'd1,
    FK_INVALID = 3'd2,
    FK_PRIV    = 3'd3,
    FK_WPROT   = 3'd4
  } fault_e;

  // flag positions inside the data word
  localparam int LO_GLB  = 4;
  localparam int LO_VAL  = 3;
  localparam int LO_KERN = 2;
  localparam int LO_WR   = 1;

  // direction code in the fault record
  localparam int          CAUSE_RW_LSB = 8;
  localparam logic [1:0]  RW_READ      = 2'b01;
  localparam logic [1:0]  RW_WRITE     = 2'b10;

endpackage

// File: rtl/mmu_tlb_store.sv
`timescale 1ns/1ps
module mmu_tlb_store #(
  parameter int NSETS = 4,
  parameter int NIDX  = 16,
  parameter int EW    = 32
) (
  input  logic                            clk,
  input  logic                            wr_en,
  input  logic [$clog2(NSETS)-1:0]        wr_set,
  input  logic [$clog2(NIDX)-1:0]         wr_idx,
  input  logic [EW-1:0]                   wr_hi,
  input  logic [EW-1:0]                   wr_lo,
  input  logic [$clog2(NIDX)-1:0]         rd_idx,
  output logic [NSETS-1:0][EW-1:0]        rd_hi,
  output logic [NSETS-1:0][EW-1:0]        rd_lo
);
  localparam int SET_W = $clog2(NSETS);

  for (genvar s = 0; s < NSETS; s++) begin : g_way
    logic [EW-1:0] hi_mem [NIDX];
    logic [EW-1:0] lo_mem [NIDX];

    always_ff @(posedge clk) begin
      if (wr_en && wr_set == SET_W'(s)) begin
        hi_mem[wr_idx] <= wr_hi;
        lo_mem[wr_idx] <= wr_lo;
      end
    end

    assign rd_hi[s] = hi_mem[rd_idx];
    assign rd_lo[s] = lo_mem[rd_idx];
  end

endmodule

// File: rtl/mmu_tlb_check.sv
`timescale 1ns/1ps
module mmu_tlb_check
  import mmu_xlate_pkg::*;
#(
  parameter int NSETS     = 4,
  parameter int EW        = 32,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8
) (
  input  logic [NSETS-1:0][EW-1:0]   set_hi,
  input  logic [NSETS-1:0][EW-1:0]   set_lo,
  input  logic [EW-PAGE_BITS-1:0]    vpn,
  input  logic [PID_W-1:0]           pid,
  input  logic                       acc_wr,
  input  logic                       acc_user,
  input  logic                       chk_wr,
  input  logic                       chk_kern,
  input  logic                       chk_valid,
  output logic                       hit,
  output logic [EW-PAGE_BITS-1:0]    hit_pfn,
  output logic                       hit_glb,
  output logic [PID_W-1:0]           hit_pid,
  output fault_e                     kind
);
  logic [NSETS-1:0] match;
  logic [EW-1:0]    sel_lo;
  logic             unused_fields;

  for (genvar s = 0; s < NSETS; s++) begin : g_cmp
    assign match[s] = (set_hi[s][EW-1:PAGE_BITS] == vpn) &&
                      (set_lo[s][LO_GLB] || set_hi[s][PID_W-1:0] == pid);
  end

  // lowest-numbered way wins: scan downwards so the last hit kept is the lowest
  always_comb begin
    hit     = 1'b0;
    sel_lo  = '0;
    hit_pid = '0;
    for (int s = NSETS - 1; s >= 0; s--) begin
      if (match[s]) begin
        hit     = 1'b1;
        sel_lo  = set_lo[s];
        hit_pid = set_hi[s][PID_W-1:0];
      end
    end
  end

  assign hit_pfn = sel_lo[EW-1:PAGE_BITS];
  assign hit_glb = sel_lo[LO_GLB];

  always_comb begin
    if (!hit)                                 kind = FK_REFILL;
    else if (chk_valid && !sel_lo[LO_VAL])    kind = FK_INVALID;
    else if (acc_user && chk_kern && sel_lo[LO_KERN]) kind = FK_PRIV;
    else if (acc_wr && chk_wr && !sel_lo[LO_WR])      kind = FK_WPROT;
    else                                      kind = FK_NONE;
  end

  assign unused_fields = ^{set_hi, set_lo};

endmodule

// File: rtl/mmu_fault_regs.sv
`timescale 1ns/1ps
module mmu_fault_regs
  import mmu_xlate_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  parameter int SET_W     = 2,
  parameter int IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic                        refill,
  input  logic                        acc_wr,
  input  logic [AW-PAGE_BITS-1:0]     vpn,
  input  logic [PID_W-1:0]            pid,
  output logic [AW-1:0]               cause_q,
  output logic [SET_W+IDX_W-1:0]      sel_q
);
  logic [AW-1:0] cause_d;

  always_comb begin
    cause_d                           = '0;
    cause_d[AW-1:PAGE_BITS]           = vpn;
    cause_d[CAUSE_RW_LSB +: 2]        = acc_wr ? RW_WRITE : RW_READ;
    cause_d[PID_W-1:0]                = pid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      sel_q   <= '0;
    end else if (capture) begin
      cause_q <= cause_d;
      if (refill) sel_q <= {{SET_W{1'b0}}, vpn[IDX_W-1:0]};
    end
  end

  a_r13_cause_fields: assert property (@(posedge clk) disable iff (rst)
    capture |=> (cause_q[PID_W-1:0] == $past(pid) &&
                 cause_q[AW-1:PAGE_BITS] == $past(vpn)));

  a_r13_cause_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(cause_q));

  a_r12_sel_load: assert property (@(posedge clk) disable iff (rst)
    (capture && refill) |=> (sel_q[IDX_W-1:0] == $past(vpn[IDX_W-1:0]) &&
                             sel_q[SET_W+IDX_W-1:IDX_W] == '0));

  a_r12_sel_hold: assert property (@(posedge clk) disable iff (rst)
    !(capture && refill) |=> $stable(sel_q));

endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 13,
  parameter int SEG_BITS  = 4,
  parameter int NSETS     = 4,
  parameter int NIDX      = 16,
  parameter int PID_W     = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [1:0]                             xl_mode,
  input  logic [(1<<SEG_BITS)-1:0]               seg_direct,
  input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0]  kbase_lo,
  input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0]  kbase_hi,
  input  logic                                   chk_wr,
  input  logic                                   chk_kern,
  input  logic                                   chk_valid,
  input  logic                                   acc_valid,
  input  logic [AW-1:0]                          va,
  input  logic                                   acc_wr,
  input  logic                                   acc_user,
  input  logic [PID_W-1:0]                       cur_pid,
  input  logic                                   tlb_we,
  input  logic [$clog2(NSETS)-1:0]               tlb_set,
  input  logic [$clog2(NIDX)-1:0]                tlb_idx,
  input  logic [AW-1:0]                          tlb_hi,
  input  logic [AW-1:0]                          tlb_lo,
  output logic [AW-1:0]                          pa,
  output logic                                   xl_miss,
  output logic [2:0]                             xl_fault,
  output logic [AW-1:0]                          mm_cause,
  output logic [$clog2(NSETS)+$clog2(NIDX)-1:0]  mm_sel
);
  localparam int HALF  = (1 << SEG_BITS) / 2;
  localparam int SET_W = $clog2(NSETS);
  localparam int IDX_W = $clog2(NIDX);
  localparam int VPN_W = AW - PAGE_BITS;

  logic [SEG_BITS-1:0]        seg, seg_base;
  logic [VPN_W-1:0]           vpn;
  logic                       xl_on, direct, paged;
  logic [NSETS-1:0][AW-1:0]   way_hi, way_lo;
  logic                       hit, hit_glb;
  logic [VPN_W-1:0]           hit_pfn;
  logic [PID_W-1:0]           hit_pid;
  fault_e                     kind;

  assign seg    = va[AW-1 -: SEG_BITS];
  assign vpn    = va[AW-1:PAGE_BITS];
  assign xl_on  = |xl_mode;
  assign direct = xl_on && seg_direct[seg];
  assign paged  = xl_on && !seg_direct[seg];

  always_comb begin
    if (int'(seg) < HALF) seg_base = kbase_lo[int'(seg) * SEG_BITS +: SEG_BITS];
    else                  seg_base = kbase_hi[(int'(seg) - HALF) * SEG_BITS +: SEG_BITS];
  end

  mmu_tlb_store #(.NSETS(NSETS), .NIDX(NIDX), .EW(AW)) u_store (
    .clk    (clk),
    .wr_en  (tlb_we),
    .wr_set (tlb_set),
    .wr_idx (tlb_idx),
    .wr_hi  (tlb_hi),
    .wr_lo  (tlb_lo),
    .rd_idx (vpn[IDX_W-1:0]),
    .rd_hi  (way_hi),
    .rd_lo  (way_lo)
  );

  mmu_tlb_check #(.NSETS(NSETS), .EW(AW), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)) u_check (
    .set_hi    (way_hi),
    .set_lo    (way_lo),
    .vpn       (vpn),
    .pid       (cur_pid),
    .acc_wr    (acc_wr),
    .acc_user  (acc_user),
    .chk_wr    (chk_wr),
    .chk_kern  (chk_kern),
    .chk_valid (chk_valid),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .hit_glb   (hit_glb),
    .hit_pid   (hit_pid),
    .kind      (kind)
  );

  always_comb begin
    pa       = va;
    xl_miss  = 1'b0;
    xl_fault = FK_NONE;
    if (direct) begin
      pa = {seg_base, va[AW-SEG_BITS-1:0]};
    end else if (paged) begin
      if (hit) pa = {hit_pfn, va[PAGE_BITS-1:0]};
      xl_miss  = (kind != FK_NONE);
      xl_fault = kind;
    end
  end

  mmu_fault_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W),
                   .SET_W(SET_W), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .capture (acc_valid && paged && kind != FK_NONE),
    .refill  (kind == FK_REFILL),
    .acc_wr  (acc_wr),
    .vpn     (vpn),
    .pid     (cur_pid),
    .cause_q (mm_cause),
    .sel_q   (mm_sel)
  );

  a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
    !xl_on |-> (pa == va && !xl_miss && xl_fault == 3'd0));

  a_r2_direct_offset: assert property (@(posedge clk) disable iff (rst)
    direct |-> (pa[AW-SEG_BITS-1:0] == va[AW-SEG_BITS-1:0] && !xl_miss));

  a_r5_pid_rule: assert property (@(posedge clk) disable iff (rst)
    (paged && hit) |-> (hit_glb || hit_pid == cur_pid));

  a_r7_refill_flag: assert property (@(posedge clk) disable iff (rst)
    (paged && !hit) |-> (xl_miss && xl_fault == 3'd1 && pa == va));

  a_r3_page_offset: assert property (@(posedge clk) disable iff (rst)
    (paged && hit) |-> (pa[PAGE_BITS-1:0] == va[PAGE_BITS-1:0]));

endmodule

// File: tb/mmu_xlate_tb.sv
`timescale 1ns/1ps
module mmu_xlate_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  xl_mode;
  logic [15:0] seg_direct;
  logic [31:0] kbase_lo, kbase_hi;
  logic        chk_wr, chk_kern, chk_valid;
  logic        acc_valid, acc_wr, acc_user;
  logic [31:0] va;
  logic [7:0]  cur_pid;
  logic        tlb_we;
  logic [1:0]  tlb_set;
  logic [3:0]  tlb_idx;
  logic [31:0] tlb_hi, tlb_lo;
  logic [31:0] pa;
  logic        xl_miss;
  logic [2:0]  xl_fault;
  logic [31:0] mm_cause;
  logic [5:0]  mm_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_hi [4][16];
  logic [31:0] m_lo [4][16];
  logic [31:0] exp_cause;
  logic [5:0]  exp_sel;

  always #4 clk = ~clk;

  mmu_xlate u_dut (
    .clk(clk), .rst(rst), .xl_mode(xl_mode), .seg_direct(seg_direct),
    .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .chk_wr(chk_wr),
    .chk_kern(chk_kern), .chk_valid(chk_valid), .acc_valid(acc_valid),
    .va(va), .acc_wr(acc_wr), .acc_user(acc_user), .cur_pid(cur_pid),
    .tlb_we(tlb_we), .tlb_set(tlb_set), .tlb_idx(tlb_idx),
    .tlb_hi(tlb_hi), .tlb_lo(tlb_lo), .pa(pa), .xl_miss(xl_miss),
    .xl_fault(xl_fault), .mm_cause(mm_cause), .mm_sel(mm_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected behaviour, from the requirements
  function automatic void model(input logic [31:0] a, input logic w, input logic u,
                                input logic [7:0] p, output logic [31:0] epa,
                                output logic emiss, output logic [2:0] ek,
                                output logic epaged, output string tag);
    logic [3:0]  sg, base, ix;
    logic [31:0] lo;
    int          nv, nm, found, nc;
    logic        c_inv, c_ker, c_wr;
    epa = a; emiss = 1'b0; ek = 3'd0; epaged = 1'b0; tag = "R1";
    if (xl_mode == 2'b00) return;
    sg = a[31:28];
    if (seg_direct[sg]) begin
      base = (sg < 4'd8) ? kbase_lo[int'(sg)*4 +: 4] : kbase_hi[(int'(sg)-8)*4 +: 4];
      epa = {base, a[27:0]};
      tag = "R2";
      return;
    end
    epaged = 1'b1;
    ix = a[16:13];
    nv = 0; nm = 0; found = -1;
    for (int s = 3; s >= 0; s--) begin
      if (m_hi[s][ix][31:13] == a[31:13]) begin
        nv++;
        if (m_lo[s][ix][4] || m_hi[s][ix][7:0] == p) begin
          nm++;
          found = s;
        end
      end
    end
    if (found < 0) begin
      emiss = 1'b1; ek = 3'd1;
      tag = (nv > 0) ? "R5,R7" : "R7";
      return;
    end
    lo = m_lo[found][ix];
    epa = {lo[31:13], a[12:0]};
    c_inv = chk_valid && !lo[3];
    c_ker = u && chk_kern && lo[2];
    c_wr  = w && chk_wr && !lo[1];
    nc = int'(c_inv) + int'(c_ker) + int'(c_wr);
    if (c_inv)      ek = 3'd2;
    else if (c_ker) ek = 3'd3;
    else if (c_wr)  ek = 3'd4;
    emiss = (ek != 3'd0);
    if (nc > 1)      tag = "R11";
    else if (c_inv)  tag = "R8";
    else if (c_ker)  tag = "R9";
    else if (c_wr)   tag = "R10";
    else if (nm > 1) tag = "R6";
    else             tag = "R3,R4";
  endfunction

  task automatic access(input logic [31:0] a, input logic w, input logic u,
                        input logic [7:0] p, input logic v);
    logic [31:0] epa;
    logic        em, ep;
    logic [2:0]  ek;
    string       tag;
    va = a; acc_wr = w; acc_user = u; cur_pid = p; acc_valid = v;
    #1;
    model(a, w, u, p, epa, em, ek, ep, tag);
    chk({tag, " pa"}, pa, epa);
    chk({tag, " miss"}, {31'b0, xl_miss}, {31'b0, em});
    chk({tag, " kind"}, {29'b0, xl_fault}, {29'b0, ek});
    if (v && ep && em) begin
      exp_cause = {a[31:13], 3'b000, (w ? 2'b10 : 2'b01), p};
      if (ek == 3'd1) exp_sel = {2'b00, a[16:13]};
    end
    @(posedge clk); #1;
    chk("R13 cause register", mm_cause, exp_cause);
    chk("R12 refill-slot register", {26'b0, mm_sel}, {26'b0, exp_sel});
    @(negedge clk);
  endtask

  task automatic write_tlb(input int s, input int i, input logic [31:0] hi, input logic [31:0] lo);
    tlb_we = 1'b1; tlb_set = 2'(s); tlb_idx = 4'(i); tlb_hi = hi; tlb_lo = lo;
    m_hi[s][i] = hi; m_lo[s][i] = lo;
    @(posedge clk); #1;
    tlb_we = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [18:0] vpn_of(input int s, input int i);
    if (s == 3 && (i % 4) == 0) return {4'(1), 11'(i*7 + 1), 4'(i)};
    return {4'(s), 11'(i*7 + s), 4'(i)};
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] fl;
    rst = 1'b1; xl_mode = 2'b00; seg_direct = 16'h0;
    kbase_lo = 32'h9ABC_DEF1; kbase_hi = 32'h2468_ACE0;
    chk_wr = 0; chk_kern = 0; chk_valid = 0;
    acc_valid = 0; acc_wr = 0; acc_user = 0; va = 32'h0; cur_pid = 8'h0;
    tlb_we = 0; tlb_set = 0; tlb_idx = 0; tlb_hi = 0; tlb_lo = 0;
    exp_cause = 32'h0; exp_sel = 6'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R13 reset cause", mm_cause, 32'h0);
    chk("R12 reset sel", {26'b0, mm_sel}, 32'h0);
    @(negedge clk);

    // R4: fill every slot
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 16; i++) begin
        fl = 5'((i*3 + s*5) & 31);
        if ((s == 1 || s == 3) && (i % 4) == 0) fl[4] = 1'b1;
        write_tlb(s, i, {vpn_of(s, i), 5'b0, 8'(i + s*16)},
                        {19'(i*1000 + s*77 + 5), 8'b0, fl});
      end
    end

    xl_mode = 2'b01;
    seg_direct = 16'hF0F0;
    for (int c = 0; c < 8; c++) begin
      chk_valid = c[0]; chk_kern = c[1]; chk_wr = c[2];
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 16; i++)
          for (int k = 0; k < 8; k++)
            access({vpn_of(s, i), 13'((s*i*37 + 5 + k) & 8191)}, k[1], k[2],
                   k[0] ? 8'(i + s*16) : 8'hEE, 1'b1);
    end

    // R7: misses in paged segments 8..11, some with acc_valid low (R13 hold)
    chk_valid = 1; chk_kern = 1; chk_wr = 1;
    for (int k = 0; k < 32; k++)
      access({4'(8 + k % 4), 15'(k*123), 13'(k*5)}, k[0], k[1], 8'(k*9), k[2]);

    // R4: overwrite one slot and use it
    write_tlb(2, 5, {19'h5_1235, 5'b0, 8'h33}, {19'h7_0F0F, 8'b0, 5'b01011});
    access({19'h5_1235, 13'h0ABC}, 1'b1, 1'b0, 8'h33, 1'b1);
    access({19'h5_1235, 13'h0ABC}, 1'b0, 1'b1, 8'h34, 1'b1);

    // R2: all segments direct, under both enable codes
    seg_direct = 16'hFFFF;
    for (int k = 0; k < 64; k++) begin
      xl_mode = k[5] ? 2'b10 : 2'b11;
      access({4'(k % 16), 28'(k * 32'h0123_4567)}, k[0], k[1], 8'(k), 1'b1);
    end

    // R1: bypass even for addresses that would hit or miss
    xl_mode = 2'b00; seg_direct = 16'h0;
    for (int k = 0; k < 32; k++)
      access({vpn_of(k % 4, k % 16), 13'(k*77)} ^ (k[4] ? 32'h8000_0000 : 32'h0),
             k[0], k[1], 8'(k), 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule